// File: doc/BRIEF.md
# Fault-Tolerant Write-Through Cache Controller

This block runs one level of a direct-mapped, write-through cache whose storage may contain known-bad words. A per-index fault bit, loaded from outside (for example by a memory test run at start-up), marks a word as unusable. Any access to a marked word takes the ordinary miss path, so the lower memory level serves it. A storage defect therefore costs latency but never returns wrong data.

The processor issues single-word reads and writes with a one-cycle request pulse and waits for a one-cycle ready pulse. Hits are served from the local array. Read misses, faulty words and every write go to the next level down over a request/ready handshake: the request is held until ready. Write hits and write misses both allocate the word locally unless its fault bit is set. A faulty word is never allocated, and writing one clears its valid bit.

Top module: `ft_wt_cache`

## Requirements
- R1: After reset, `cpu_ready_o` and `mem_req_o` are low and every entry is invalid, so the first read of any address is a miss.
- R2: A read whose index holds a valid entry with an equal tag and a clear fault bit is a hit. `cpu_ready_o` pulses in the second cycle after the request is sampled and returns the stored word. No lower-level request is made.
- R3: A read miss raises `mem_req_o` with `mem_we_o` low and `mem_addr_o` equal to the address, and holds it stable until `mem_ready_i`. With a lower-level delay of D cycles, the ready pulse comes D+3 cycles after the request and returns `mem_rdata_i`. The word is allocated when its fault bit is clear.
- R4: Every write, hit or miss, raises `mem_req_o` with `mem_we_o` high and carries the address and data down. `cpu_ready_o` pulses in the cycle after `mem_ready_i`. The local word is written and marked valid when its fault bit is clear.
- R5: When the fault bit of the addressed index is set, an access is treated as a miss and served by the lower level, even if a matching valid entry exists.
- R6: An access to a faulty index never allocates. After that access the entry is invalid, so it misses again once the fault bit is cleared.
- R7: A fault-map load (`fm_we_i`, bit `fm_bit_i` at index `fm_idx_i`) takes effect only while the controller is idle. A load presented during an access is discarded.
- R8: A processor request presented while an access is in progress is ignored. It causes no lower-level request, no ready pulse and no memory write.
- R9: An address whose index matches a valid entry but whose tag differs is a miss and replaces that entry. The address is the tag in the upper bits and the index in the lower `IDX_W` bits.
- R10: `cpu_ready_o` is high for exactly one cycle per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, sampled only when idle |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | TAG_W+IDX_W | Word address {tag, index} |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| fm_we_i | input | 1 | Fault-map load enable |
| fm_idx_i | input | IDX_W | Fault-map index to load |
| fm_bit_i | input | 1 | Fault bit value (1 = faulty) |
| mem_req_o | output | 1 | Lower-level request, held until ready |
| mem_we_o | output | 1 | Lower-level write |
| mem_addr_o | output | TAG_W+IDX_W | Lower-level word address |
| mem_wdata_o | output | DATA_W | Lower-level write data |
| mem_rdata_i | input | DATA_W | Lower-level read data |
| mem_ready_i | input | 1 | Lower-level completion |

## Verification
A corrupted valid bit, tag or fault bit shows at the ports on the next access to that index. Latency moves between 2 cycles and D+3 cycles, and a lower-level request appears or fails to appear. A stale local word shows as wrong read data on the first hit after it. A lost fault-map gate or a lost request gate shows during the access that overlaps it: as an extra ready pulse or lower-level write, or as a later hit that should have missed.

// File: rtl/ft_cache_pkg.sv
package ft_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_MISS,
    ST_RD_WAIT,
    ST_RD_DATA,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_WR_DATA
  } ctl_state_e;
endpackage

// File: rtl/ft_fault_map.sv
module ft_fault_map #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic             ld_bit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             fault_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] bits_q;
  logic               ld_ok;

  assign ld_ok = ld_en_i & idle_i;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       bits_q[e] <= 1'b0;
      else if (ld_ok && ld_idx_i == IDX_W'(e))           bits_q[e] <= ld_bit_i;
    end
  end

  assign fault_o = bits_q[rd_idx_i];

  // R7: map frozen while an access runs
  a_r7_load_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(bits_q));
endmodule

// File: rtl/ft_line_store.sv
module ft_line_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic              upd_en_i,
  input  logic              upd_drop_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic [DATA_W-1:0] upd_data_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = upd_en_i && upd_idx_i == IDX_W'(e);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[e] <= 1'b0;
      else if (sel) valid_q[e] <= ~upd_drop_i;
    end

    always_ff @(posedge clk_i) begin
      if (sel && !upd_drop_i) begin
        tag_q[e]  <= upd_tag_i;
        data_q[e] <= upd_data_i;
      end
    end

    // R6: faulty word leaves its entry invalid
    a_r6_drop_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel && upd_drop_i |=> !valid_q[e]);
  end

  assign hit_o     = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_data_o = data_q[lk_idx_i];
endmodule

// File: rtl/ft_ctrl_fsm.sv
module ft_ctrl_fsm
  import ft_cache_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              idle_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  input  logic              hit_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              upd_en_o,
  output logic              upd_drop_o,
  output logic [DATA_W-1:0] upd_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  ctl_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, miss_q, fault_q;
  logic              good_hit;

  assign good_hit = hit_i & ~fault_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (we_q)          st_d = ST_WR_REQ;
        else if (good_hit) st_d = ST_RD_DATA;
        else               st_d = ST_RD_MISS;
      end
      ST_RD_MISS: st_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_ready_i) st_d = ST_RD_DATA;
      ST_RD_DATA: st_d = ST_IDLE;
      ST_WR_REQ:  st_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_ready_i) st_d = ST_WR_DATA;
      ST_WR_DATA: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
      end
      if (st_q == ST_CHECK) begin
        miss_q  <= ~good_hit;
        fault_q <= fault_i;
        if (!we_q && good_hit) rdata_q <= lk_data_i;
      end
      if (st_q == ST_RD_WAIT && mem_ready_i) rdata_q <= mem_rdata_i;
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign lk_idx_o    = addr_q[IDX_W-1:0];
  assign lk_tag_o    = addr_q[ADDR_W-1:IDX_W];
  assign ready_o     = (st_q == ST_RD_DATA) || (st_q == ST_WR_DATA);
  assign rdata_o     = rdata_q;
  assign mem_req_o   = (st_q == ST_RD_MISS) || (st_q == ST_RD_WAIT) ||
                       (st_q == ST_WR_REQ)  || (st_q == ST_WR_WAIT);
  assign mem_we_o    = (st_q == ST_WR_REQ)  || (st_q == ST_WR_WAIT);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign upd_en_o    = (st_q == ST_WR_DATA) || (st_q == ST_RD_DATA && miss_q);
  assign upd_drop_o  = fault_q;
  assign upd_data_o  = (st_q == ST_WR_DATA) ? wdata_q : rdata_q;

  // R10
  a_r10_ready_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R3
  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R4
  a_r4_write_goes_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CHECK && we_q |=> mem_req_o && mem_we_o);
  // R5
  a_r5_fault_forces_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CHECK && fault_i |=> st_q == ST_RD_MISS || st_q == ST_WR_REQ);
  // R2
  a_r2_hit_stays_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CHECK && !we_q && good_hit |=> ready_o && !mem_req_o);
  // R8
  a_r8_busy_no_ready_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o && !ready_o |=> !$rose(idle_o));
endmodule

// File: rtl/ft_wt_cache.sv
module ft_wt_cache #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  input  logic              fm_we_i,
  input  logic [IDX_W-1:0]  fm_idx_i,
  input  logic              fm_bit_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  logic              idle;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              hit, fault;
  logic [DATA_W-1:0] lk_data, upd_data;
  logic              upd_en, upd_drop;

  ft_ctrl_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_i       (cpu_req_i),
    .we_i        (cpu_we_i),
    .addr_i      (cpu_addr_i),
    .wdata_i     (cpu_wdata_i),
    .rdata_o     (cpu_rdata_o),
    .ready_o     (cpu_ready_o),
    .idle_o      (idle),
    .lk_idx_o    (lk_idx),
    .lk_tag_o    (lk_tag),
    .hit_i       (hit),
    .fault_i     (fault),
    .lk_data_i   (lk_data),
    .upd_en_o    (upd_en),
    .upd_drop_o  (upd_drop),
    .upd_data_o  (upd_data),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i
  );

  ft_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .lk_idx_i   (lk_idx),
    .lk_tag_i   (lk_tag),
    .hit_o      (hit),
    .lk_data_o  (lk_data),
    .upd_en_i   (upd_en),
    .upd_drop_i (upd_drop),
    .upd_idx_i  (lk_idx),
    .upd_tag_i  (lk_tag),
    .upd_data_i (upd_data)
  );

  ft_fault_map #(.IDX_W(IDX_W)) u_fmap (
    .clk_i, .rst_ni,
    .idle_i   (idle),
    .ld_en_i  (fm_we_i),
    .ld_idx_i (fm_idx_i),
    .ld_bit_i (fm_bit_i),
    .rd_idx_i (lk_idx),
    .fault_o  (fault)
  );

  // R1
  a_r1_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !cpu_ready_o && !mem_req_o);
endmodule

// File: tb/tb_ft_wt_cache.sv
module tb_ft_wt_cache;
  localparam int IDX_W = 4, TAG_W = 8, DATA_W = 32, ADDR_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_i = 0, cpu_we_i = 0;
  logic [ADDR_W-1:0] cpu_addr_i = '0;
  logic [DATA_W-1:0] cpu_wdata_i = '0, cpu_rdata_o;
  logic cpu_ready_o;
  logic fm_we_i = 0, fm_bit_i = 0;
  logic [IDX_W-1:0] fm_idx_i = '0;
  logic mem_req_o, mem_we_o, mem_ready_i = 0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o, mem_rdata_i = '0;

  always #2.5 clk = ~clk;

  ft_wt_cache dut (.clk_i(clk), .rst_ni(rst_n), .*);

  int checks = 0, errors = 0, nreq = 0, dly = 2, cnt = 0;
  logic [DATA_W-1:0] mem_model [1<<ADDR_W];
  bit ref_valid [1<<IDX_W];
  bit ref_fault [1<<IDX_W];
  logic [TAG_W-1:0] ref_tag [1<<IDX_W];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lower-level memory model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_o) begin
        if (cnt == dly) begin
          mem_ready_i = 1;
          if (mem_we_o) mem_model[mem_addr_o] = mem_wdata_o;
          else          mem_rdata_i = mem_model[mem_addr_o];
          nreq++;
          cnt = 0;
        end else begin
          mem_ready_i = 0;
          cnt++;
        end
      end else begin
        mem_ready_i = 0;
        cnt = 0;
      end
    end
  end

  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat, output bit used);
    int n0;
    @(negedge clk);
    cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    n0 = nreq;
    @(negedge clk);
    cpu_req_i = 0;
    lat = 1;
    while (!cpu_ready_o && lat < 200) begin @(negedge clk); lat++; end
    rd = cpu_rdata_o;
    used = (nreq != n0);
  endtask

  // access with expectations from the reference tag model
  task automatic run(input bit we, input logic [ADDR_W-1:0] a, input logic [31:0] wd, input string req);
    logic [31:0] rd; int lat; bit used; bit exp_hit;
    logic [IDX_W-1:0] i;
    i = a[IDX_W-1:0];
    exp_hit = !we && ref_valid[i] && ref_tag[i] == a[ADDR_W-1:IDX_W] && !ref_fault[i];
    access(we, a, wd, rd, lat, used);
    chk(lat == (exp_hit ? 2 : dly + 3), req, "latency", lat, exp_hit ? 2 : dly + 3);
    chk(used == !exp_hit, req, "lower request used", used, !exp_hit);
    if (!we) chk(rd == mem_model[a], req, "read data", rd, mem_model[a]);
    else     chk(mem_model[a] == wd, req, "write-through data", mem_model[a], wd);
    ref_valid[i] = !ref_fault[i];
    ref_tag[i]   = a[ADDR_W-1:IDX_W];
  endtask

  task automatic load_fault(input logic [IDX_W-1:0] i, input bit b);
    @(negedge clk);
    fm_we_i = 1; fm_idx_i = i; fm_bit_i = b;
    @(negedge clk);
    fm_we_i = 0;
    ref_fault[i] = b;
  endtask

  task automatic t_reset();
    chk(cpu_ready_o == 0, "R1", "ready after reset", cpu_ready_o, 0);
    chk(mem_req_o == 0, "R1", "mem_req after reset", mem_req_o, 0);
    run(0, 12'h113, 0, "R1");
  endtask

  task automatic t_read();
    run(0, 12'h11a, 0, "R3");
    run(0, 12'h11a, 0, "R2");
    run(0, 12'h113, 0, "R2");
  endtask

  task automatic t_pulse();
    logic [31:0] rd; int lat; bit used;
    access(0, 12'h113, 0, rd, lat, used);
    @(negedge clk);
    chk(cpu_ready_o == 0, "R10", "ready width", cpu_ready_o, 0);
  endtask

  task automatic t_write();
    run(1, 12'h113, 32'hdead_0113, "R4");
    run(0, 12'h113, 0, "R4");
    run(1, 12'h125, 32'h1234_5678, "R4");
    run(0, 12'h125, 0, "R4");
  endtask

  task automatic t_conflict();
    run(0, 12'h223, 0, "R9");
    run(0, 12'h113, 0, "R9");
    run(0, 12'h113, 0, "R9");
  endtask

  task automatic t_fault();
    load_fault(4'h3, 1);
    run(0, 12'h113, 0, "R5");
    run(0, 12'h113, 0, "R5");
    run(1, 12'h113, 32'hfeed_f00d, "R5");
    load_fault(4'h3, 0);
    run(0, 12'h113, 0, "R6");
    run(0, 12'h113, 0, "R6");
  endtask

  task automatic t_busy();
    logic [31:0] rd, keep; int lat; bit used; int n0;
    dly = 6;
    keep = mem_model[12'h348];
    fork
      access(0, 12'h337, 0, rd, lat, used);
      begin
        repeat (4) @(negedge clk);
        cpu_req_i = 1; cpu_we_i = 1; cpu_addr_i = 12'h348; cpu_wdata_i = 32'hbad0_0bad;
        fm_we_i = 1; fm_idx_i = 4'h7; fm_bit_i = 1;
        @(negedge clk);
        cpu_req_i = 0; fm_we_i = 0;
      end
    join
    chk(rd == mem_model[12'h337], "R3", "busy-case read data", rd, mem_model[12'h337]);
    ref_valid[7] = 1; ref_tag[7] = 8'h33;
    n0 = nreq;
    begin
      bit extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (cpu_ready_o || mem_req_o) extra = 1;
      end
      chk(extra == 0, "R8", "activity after ignored request", extra, 0);
    end
    chk(nreq == n0, "R8", "lower requests", nreq, n0);
    chk(mem_model[12'h348] == keep, "R8", "memory untouched", mem_model[12'h348], keep);
    run(0, 12'h337, 0, "R7");
    dly = 2;
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem_model[i] = (i * 32'h9e37_79b1) ^ 32'h5a5a_0000;
    for (int i = 0; i < (1 << IDX_W); i++) begin ref_valid[i] = 0; ref_fault[i] = 0; ref_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read();
    t_pulse();
    t_write();
    t_conflict();
    t_fault();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule